// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver with Majority Voting

This block takes an asynchronous serial line and turns each frame of one low start bit, eight data bits sent least significant bit first, and one stop bit into a parallel byte. A sample-enable input fires sixteen times per bit period. The line is retimed through a two-flop synchronizer. While idle, the receiver watches each enabled sample for a high-to-low change. When it finds one, it realigns its per-bit sample counter to that edge.

Each bit is resolved by a two-of-three vote over the samples taken at positions 7, 8 and 9 of its sixteen-sample period. If the start bit votes high, the attempt is dropped. The bits are collected in a nine-bit register that is preset to all ones. The frame is known to be in once the start zero reaches the top of that register. The stop bit is voted next. At that point the byte and the stop level are stored and the ready flag is raised, provided two conditions hold: the flag is still clear, and either the stop filter is off or the stop bit is high. A frame that fails either condition is dropped without a trace. Software acknowledges a byte through a clear input.

Top module: `serial_rx_vote`

## Requirements
- R1: After reset, `frame_rdy` is 0, `rx_byte` is 0x00 and `stop_bit` is 0.
- R2: The receiver advances only on cycles with `samp_en` high. With `samp_en` held low, a complete frame on `rx_line` leaves `frame_rdy` at 0.
- R3: Take the enabled sample where the falling edge is seen as position 0. Each bit value is then the majority of the samples at positions 7, 8 and 9 of its period. A single disagreeing sample among these three does not change the bit, and two disagreeing samples do.
- R4: A start bit that votes high aborts reception without raising `frame_rdy`. The receiver then goes straight back to edge watching, so a following valid frame is received.
- R5: The first data bit after the start bit lands in `rx_byte[0]` and the last one lands in `rx_byte[7]`.
- R6: On acceptance, the voted stop level is written to `stop_bit` and `frame_rdy` is set to 1.
- R7: A frame that completes while `frame_rdy` is 1 is discarded, and `rx_byte` and `stop_bit` keep their values.
- R8: With `stop_gate` at 1, a frame whose stop bit votes 0 is discarded. With `stop_gate` at 0, the same frame is accepted and `stop_bit` reads 0.
- R9: `frame_rdy` stays 1 until `flag_clr` is high at a clock edge. Clearing it does not alter `rx_byte` or `stop_bit`.
- R10: The receiver returns to edge watching at the stop-bit vote. A start edge that follows a sixteen-sample stop bit immediately is therefore received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_en | input | 1 | Sample enable, sixteen pulses per bit period |
| rx_line | input | 1 | Serial input line, idles high |
| stop_gate | input | 1 | When 1, only frames with a high stop bit are accepted |
| flag_clr | input | 1 | Clears `frame_rdy` |
| rx_byte | output | 8 | Last accepted data byte |
| stop_bit | output | 1 | Stop level of the last accepted frame |
| frame_rdy | output | 1 | Set when a frame is accepted |

## Verification
Byte values with mixed bit patterns, such as 0xA5, 0x5A and 0x81, show whether the bit order and the stop capture are correct. Glitches are injected at chosen sample positions. A lone flipped sample inside the 7–9 window must be outvoted. Two flipped samples must flip the bit. Flips outside the window must have no effect. Together these separate a true majority vote from single-point sampling and from a misplaced window. A short low pulse on an idle line, a frame arriving while the flag is still set, and a low stop bit under both filter settings exercise the three discard paths. Back-to-back frames, a slower enable cadence and an enable held low show that timing follows only the sample enable.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_BITS = 2'd1,
      RX_STOP = 2'd2
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("serial_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/serial_rx_vote3.sv
module serial_rx_vote3 #(
   parameter int OVS      = 16,
   parameter int MID      = 8,
   parameter bit MAJORITY = 1'b1,
   localparam int CNT_W   = $clog2(OVS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_en,
   input  logic             active,
   input  logic [CNT_W-1:0] phase,
   input  logic             lvl,
   output logic             bit_vld,
   output logic             bit_val
);
   import serial_rx_pkg::*;

   localparam logic [CNT_W-1:0] PH_LO = CNT_W'(MID - 1);
   localparam logic [CNT_W-1:0] PH_MD = CNT_W'(MID);
   localparam logic [CNT_W-1:0] PH_HI = CNT_W'(MID + 1);

   if (MID < 2 || MID + 1 > OVS - 1) begin : g_bad_mid
      $error("serial_rx_vote3: MID must leave room for samples on both sides");
   end

   logic take_lo, take_md;
   assign take_lo = samp_en && active && (phase == PH_LO);
   assign take_md = samp_en && active && (phase == PH_MD);
   assign bit_vld = samp_en && active && (phase == PH_HI);

   if (MAJORITY) begin : g_maj
      logic sa_q, sb_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sa_q <= 1'b1;
            sb_q <= 1'b1;
         end else begin
            if (take_lo) sa_q <= lvl;
            if (take_md) sb_q <= lvl;
         end
      end

      assign bit_val = vote3(sa_q, sb_q, lvl);

      // R3
      vote_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_vld && (sa_q == sb_q)) |-> (bit_val == sa_q));
   end else begin : g_mid
      logic sm_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sm_q <= 1'b1;
         end else if (take_md) begin
            sm_q <= lvl;
         end
      end

      assign bit_val = sm_q;
      logic unused_lo;
      assign unused_lo = take_lo;
   end

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   localparam int CNT_W = $clog2(OVS),
   localparam int SH_W  = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              lvl,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              stop_gate,
   input  logic              flag_clr,
   output logic              active,
   output logic [CNT_W-1:0]  phase_nxt,
   output logic [DATA_W-1:0] rx_byte,
   output logic              stop_bit,
   output logic              frame_rdy
);
   import serial_rx_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("serial_rx_frame: DATA_W must be positive");
   end
   if (OVS < 4) begin : g_bad_ovs
      $error("serial_rx_frame: OVS must be at least 4");
   end

   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SH_W-1:0]   shreg_q;
   logic              prev_q;
   logic [DATA_W-1:0] buf_q;
   logic              stop_q;
   logic              ri_q;

   logic              fall;
   logic              first_bit;
   logic              accept;
   logic [DATA_W-1:0] byte_fwd;

   assign active    = (state_q != RX_IDLE);
   assign phase_nxt = (cnt_q == CNT_W'(OVS - 1)) ? '0 : cnt_q + 1'b1;
   assign fall      = samp_en && (state_q == RX_IDLE) && prev_q && !lvl;
   assign first_bit = &shreg_q;
   assign accept    = bit_vld && (state_q == RX_STOP) && !ri_q && (!stop_gate || bit_val);

   // register holds first data bit just below the start marker; flip into byte order
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign byte_fwd[gi] = shreg_q[DATA_W-1-gi];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
      end else if (samp_en) begin
         prev_q <= lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         shreg_q <= '1;
      end else begin
         case (state_q)
            RX_IDLE: begin
               if (fall) begin
                  state_q <= RX_BITS;
                  cnt_q   <= '0;
                  shreg_q <= '1;
               end
            end
            RX_BITS: begin
               if (samp_en) cnt_q <= phase_nxt;
               if (bit_vld) begin
                  if (first_bit && bit_val) begin
                     state_q <= RX_IDLE;
                  end else begin
                     shreg_q <= {shreg_q[SH_W-2:0], bit_val};
                     if (!shreg_q[SH_W-2]) state_q <= RX_STOP;
                  end
               end
            end
            RX_STOP: begin
               if (samp_en) cnt_q <= phase_nxt;
               if (bit_vld) state_q <= RX_IDLE;
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         stop_q <= 1'b0;
         ri_q   <= 1'b0;
      end else begin
         if (accept) begin
            buf_q  <= byte_fwd;
            stop_q <= bit_val;
            ri_q   <= 1'b1;
         end else if (flag_clr) begin
            ri_q   <= 1'b0;
         end
      end
   end

   assign rx_byte   = buf_q;
   assign stop_bit  = stop_q;
   assign frame_rdy = ri_q;

   // R2
   idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!samp_en && state_q != RX_IDLE) |=> ($stable(cnt_q) && $stable(shreg_q)));

   // R5
   marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_BITS) |-> shreg_q[SH_W-1]);

   // R6
   ri_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ri_q) |-> ($past(state_q) == RX_STOP));

   // R7
   buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ri_q |=> ($stable(buf_q) && $stable(stop_q)));

   // R9
   ri_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ri_q && !flag_clr) |=> ri_q);

endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int VOTE_MID    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              rx_line,
   input  logic              stop_gate,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rx_byte,
   output logic              stop_bit,
   output logic              frame_rdy
);
   localparam int CNT_W = $clog2(OVS);

   logic             lvl;
   logic             active;
   logic [CNT_W-1:0] phase;
   logic             bit_vld;
   logic             bit_val;

   serial_rx_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_line),
      .dout  (lvl)
   );

   serial_rx_vote3 #(
      .OVS      (OVS),
      .MID      (VOTE_MID),
      .MAJORITY (MAJORITY)
   ) u_vote (
      .clk     (clk),
      .rst_n   (rst_n),
      .samp_en (samp_en),
      .active  (active),
      .phase   (phase),
      .lvl     (lvl),
      .bit_vld (bit_vld),
      .bit_val (bit_val)
   );

   serial_rx_frame #(
      .DATA_W (DATA_W),
      .OVS    (OVS)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_en   (samp_en),
      .lvl       (lvl),
      .bit_vld   (bit_vld),
      .bit_val   (bit_val),
      .stop_gate (stop_gate),
      .flag_clr  (flag_clr),
      .active    (active),
      .phase_nxt (phase),
      .rx_byte   (rx_byte),
      .stop_bit  (stop_bit),
      .frame_rdy (frame_rdy)
   );

endmodule

// File: tb/serial_rx_vote_bench.sv
module serial_rx_vote_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_en = 1'b0;
   logic       rx_line = 1'b1;
   logic       stop_gate = 1'b0;
   logic       clr_pulse = 1'b0;
   logic       auto_ack = 1'b0;
   logic       flag_clr;
   logic [7:0] rx_byte;
   logic       stop_bit;
   logic       frame_rdy;

   int checks = 0;
   int fails = 0;
   int tick_div = 1;
   int tk = 0;
   int accepts = 0;
   logic rdy_d = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign flag_clr = clr_pulse | (auto_ack & frame_rdy);

   serial_rx_vote u_serial_rx_vote (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_en   (samp_en),
      .rx_line   (rx_line),
      .stop_gate (stop_gate),
      .flag_clr  (flag_clr),
      .rx_byte   (rx_byte),
      .stop_bit  (stop_bit),
      .frame_rdy (frame_rdy)
   );

   always @(negedge clk) begin
      if (tick_div == 0) begin
         samp_en = 1'b0;
         tk = 0;
      end else begin
         samp_en = (tk == 0);
         tk = (tk + 1 >= tick_div) ? 0 : tk + 1;
      end
      if (frame_rdy && !rdy_d) accepts++;
      rdy_d = frame_rdy;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      int cyc;
      cyc = (tick_div == 0) ? 3 : tick_div;
      rx_line = v;
      repeat (n * cyc) @(negedge clk);
   endtask

   // gmask flips samples j of frame bit gb (0 start, 1..8 data, 9 stop)
   task automatic send_frame(input logic [7:0] d, input logic stp, input int gb, input logic [15:0] gmask);
      logic [9:0] fr;
      fr = {stp, d, 1'b0};
      for (int b = 0; b < 10; b++) begin
         for (int j = 0; j < 16; j++) begin
            logic v;
            v = fr[b];
            if (b == gb && gmask[j]) v = ~v;
            hold(v, 1);
         end
      end
   endtask

   task automatic clear_flag();
      @(negedge clk);
      clr_pulse = 1'b1;
      @(negedge clk);
      clr_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(frame_rdy == 1'b0, "R1 frame_rdy", frame_rdy, 0);
      chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
      chk(stop_bit == 1'b0, "R1 stop_bit", stop_bit, 0);
   endtask

   task automatic t_basic();
      send_frame(8'hA5, 1'b1, -1, '0);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b1, "R6 frame_rdy", frame_rdy, 1);
      chk(rx_byte == 8'hA5, "R5 rx_byte order", rx_byte, 8'hA5);
      chk(stop_bit == 1'b1, "R6 stop_bit", stop_bit, 1);
   endtask

   task automatic t_busy();
      send_frame(8'h3C, 1'b0, -1, '0);
      hold(1'b1, 4);
      chk(rx_byte == 8'hA5, "R7 byte kept", rx_byte, 8'hA5);
      chk(stop_bit == 1'b1, "R7 stop kept", stop_bit, 1);
      clear_flag();
      chk(frame_rdy == 1'b0, "R9 cleared", frame_rdy, 0);
      chk(rx_byte == 8'hA5, "R9 byte after clear", rx_byte, 8'hA5);
   endtask

   task automatic t_gate();
      stop_gate = 1'b1;
      send_frame(8'h5A, 1'b0, -1, '0);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b0, "R8 gated discard", frame_rdy, 0);
      chk(rx_byte == 8'hA5, "R8 byte kept", rx_byte, 8'hA5);
      send_frame(8'h66, 1'b1, -1, '0);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b1 && rx_byte == 8'h66, "R8 gated accept", rx_byte, 8'h66);
      clear_flag();
      stop_gate = 1'b0;
      send_frame(8'h5A, 1'b0, -1, '0);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b1 && rx_byte == 8'h5A, "R8 open accept", rx_byte, 8'h5A);
      chk(stop_bit == 1'b0, "R8 stop low stored", stop_bit, 0);
      clear_flag();
   endtask

   task automatic t_vote();
      send_frame(8'hA5, 1'b1, 3, 16'h0100);
      hold(1'b1, 4);
      chk(rx_byte == 8'hA5, "R3 one sample outvoted", rx_byte, 8'hA5);
      clear_flag();
      send_frame(8'hA5, 1'b1, 3, 16'h0280);
      hold(1'b1, 4);
      chk(rx_byte == 8'hA1, "R3 two samples flip bit", rx_byte, 8'hA1);
      clear_flag();
      send_frame(8'h3C, 1'b1, 5, 16'hFC7F);
      hold(1'b1, 4);
      chk(rx_byte == 8'h3C, "R3 flips outside window", rx_byte, 8'h3C);
      clear_flag();
      send_frame(8'h0F, 1'b1, 0, 16'h0200);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b1 && rx_byte == 8'h0F, "R3 start one bad sample", rx_byte, 8'h0F);
      clear_flag();
   endtask

   task automatic t_false_start();
      hold(1'b0, 4);
      hold(1'b1, 30);
      chk(frame_rdy == 1'b0, "R4 no flag on false start", frame_rdy, 0);
      send_frame(8'h81, 1'b1, -1, '0);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b1 && rx_byte == 8'h81, "R4 next frame received", rx_byte, 8'h81);
      clear_flag();
   endtask

   task automatic t_back_to_back();
      int base;
      base = accepts;
      auto_ack = 1'b1;
      send_frame(8'h11, 1'b1, -1, '0);
      send_frame(8'h22, 1'b1, -1, '0);
      hold(1'b1, 4);
      auto_ack = 1'b0;
      chk(accepts - base == 2, "R10 two accepts", accepts - base, 2);
      chk(rx_byte == 8'h22, "R10 second byte", rx_byte, 8'h22);
   endtask

   task automatic t_enable();
      tick_div = 3;
      hold(1'b1, 4);
      send_frame(8'hC3, 1'b1, -1, '0);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b1 && rx_byte == 8'hC3, "R2 slow enable", rx_byte, 8'hC3);
      clear_flag();
      tick_div = 0;
      send_frame(8'h7E, 1'b1, -1, '0);
      hold(1'b1, 4);
      chk(frame_rdy == 1'b0, "R2 no enable no frame", frame_rdy, 0);
      chk(rx_byte == 8'hC3, "R2 byte untouched", rx_byte, 8'hC3);
      tick_div = 1;
      hold(1'b1, 8);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_basic();
      t_busy();
      t_gate();
      t_vote();
      t_false_start();
      t_back_to_back();
      t_enable();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule